// File: doc/BRIEF.md
# Chained Serial Loader for Channel Codes

This block is a three-wire serial slave that fills a bank of channel code registers. A host lowers the active-low select line, clocks in 16-bit command words most significant bit first, and raises select again. On that rising edge the last complete word is decoded and committed. The word holds a control bit that must be zero, a 5-bit channel index and a 10-bit code. The stored codes are driven out in parallel to downstream converters.

The serial output gives out the shift register's oldest bit on each falling serial clock edge. Each input bit therefore reappears 16 clocks later, and several devices can share one select and one clock in a chain. The word shifted in first ends up in the device at the far end of the chain. All devices commit together on the shared select edge.

The serial pins are asynchronous to the block clock. They are synchronised and edge-detected inside the block, so the block clock must run several times faster than the serial clock.

Top module: `serial_chan_prog`

## Requirements
- R1: After reset every channel code is zero and the serial output is low.
- R2: A word is 16 bits, received most significant bit first on rising serial clock edges while select is low. Bit 15 is a control bit, bits 14..10 are the channel index and bits 9..0 are the code. On the rising edge of select, a word with control bit 0 and index below 18 writes its code into that channel.
- R3: A commit changes at most the one addressed channel. All other channels keep their codes.
- R4: A word whose channel index is 18 to 31 changes no channel.
- R5: A word whose control bit (bit 15) is 1 changes no channel.
- R6: If select rises after fewer than 16 rising serial clock edges in that low window, nothing is committed.
- R7: If more than 16 rising edges occur in one low window, only the last 16 bits received are decoded.
- R8: While select is high, serial clock edges have no effect. The serial output holds its value and no channel changes.
- R9: On each falling serial clock edge while select is low, the serial output takes the bit that entered 16 rising edges earlier. The first bit of a window therefore appears at the 16th falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, the input delayed by 16 clocks, to the next device |
| codes | output | 180 | Stored codes, channel k in bits [10k+9:10k] |

## Verification
The bench builds the block with its default parameters: 18 channels of 10-bit codes, a 5-bit index and two synchroniser stages. With these values the index field can name 14 channels that do not exist, so the discard path for indices 18 to 31 can be reached. Both end channels, 0 and 17, are written, and codes are driven at both rails. A 32-bit window exercises the chain tap and the rule that the last 16 bits win in a single run.

// File: rtl/serial_chan_prog.sv
module serial_chan_prog #(
  parameter int NCH  = 18,
  parameter int CW   = 10,
  parameter int AW   = 5,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic [NCH*CW-1:0] codes
);
  localparam int FRAME = 1 + AW + CW;
  localparam int CNTW  = $clog2(FRAME + 1);

  logic [SYNC-1:0]  sck_p, sel_p, sdi_p;
  logic             sck_q, sel_q;
  logic [FRAME-1:0] shreg;
  logic [CNTW-1:0]  cnt;
  logic [NCH-1:0]   wr_en;

  wire sck_s = sck_p[SYNC-1];
  wire sel_s = sel_p[SYNC-1];
  wire sdi_s = sdi_p[SYNC-1];

  wire rise   = sck_s & ~sck_q & ~sel_s;
  wire fall   = ~sck_s & sck_q & ~sel_s;
  wire commit = sel_s & ~sel_q;

  wire          ctrl = shreg[FRAME-1];
  wire [AW-1:0] addr = shreg[FRAME-2 -: AW];
  wire [CW-1:0] dat  = shreg[CW-1:0];
  wire          full = (cnt == CNTW'(FRAME));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sel_p <= '1;
      sdi_p <= '0;
      sck_q <= 1'b0;
      sel_q <= 1'b1;
    end else begin
      sck_p <= {sck_p[SYNC-2:0], sck};
      sel_p <= {sel_p[SYNC-2:0], sel_n};
      sdi_p <= {sdi_p[SYNC-2:0], sdi};
      sck_q <= sck_s;
      sel_q <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      sdo   <= 1'b0;
    end else begin
      if (rise) shreg <= {shreg[FRAME-2:0], sdi_s};
      if (sel_s) cnt <= '0;
      else if (rise && !full) cnt <= cnt + 1'b1;
      if (fall) sdo <= shreg[FRAME-1];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign wr_en[i] = commit & full & ~ctrl & (addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) codes[i*CW +: CW] <= '0;
      else if (wr_en[i]) codes[i*CW +: CW] <= dat;
    end
  end

  assert_one_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

  assert_commit_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(codes));

  assert_bad_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr >= AW'(NCH)) |=> $stable(codes));

  assert_ctrl_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && ctrl) |=> $stable(codes));

  assert_short_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !full) |=> $stable(codes));

  assert_gated_sdo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> ($stable(sdo) && $stable(shreg)));

endmodule

// File: tb/serial_chan_prog_bench.sv
module serial_chan_prog_bench;
  localparam int NCH = 18;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic [NCH*CW-1:0] codes;

  int checks = 0;
  int errors = 0;
  logic [CW-1:0] exp_code [NCH];

  always #10 clk = ~clk;

  serial_chan_prog u_serial_chan_prog (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .codes(codes)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] word(input logic c, input int a, input int v);
    return {c, 5'(a), 10'(v)};
  endfunction

  task automatic clock_bit(input logic b);
    sdi = b;
    wait_clk(6);
    sck = 1'b1;
    wait_clk(6);
    sck = 1'b0;
    wait_clk(6);
  endtask

  task automatic open_win();
    sck = 1'b0;
    sel_n = 1'b0;
    wait_clk(6);
  endtask

  task automatic close_win();
    sel_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic send(input logic [15:0] w);
    open_win();
    for (int i = 15; i >= 0; i--) clock_bit(w[i]);
    close_win();
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NCH; k++)
      chk(req, int'(codes[k*CW +: CW]), int'(exp_code[k]));
  endtask

  task automatic t_reset();
    chk("R1 sdo", int'(sdo), 0);
    check_all("R1");
  endtask

  task automatic t_writes();
    send(word(1'b0, 0, 1023)); exp_code[0] = 10'd1023;
    check_all("R2 ch0");
    send(word(1'b0, 17, 31));  exp_code[17] = 10'd31;
    check_all("R3 ch17");
    send(word(1'b0, 2, 513));  exp_code[2] = 10'd513;
    check_all("R3 ch2");
    send(word(1'b0, 0, 512));  exp_code[0] = 10'd512;
    check_all("R2 overwrite");
    send(word(1'b0, 7, 0));    exp_code[7] = 10'd0;
    check_all("R2 zero");
  endtask

  task automatic t_bad_addr();
    send(word(1'b0, 18, 700));
    check_all("R4 addr18");
    send(word(1'b0, 31, 5));
    check_all("R4 addr31");
  endtask

  task automatic t_ctrl();
    send(word(1'b1, 3, 444));
    check_all("R5 ctrl");
  endtask

  task automatic t_short();
    logic [15:0] w;
    w = word(1'b0, 4, 321);
    open_win();
    for (int i = 15; i >= 1; i--) clock_bit(w[i]);
    close_win();
    check_all("R6 15 clocks");
  endtask

  task automatic t_long_chain();
    logic [31:0] s;
    s = {word(1'b0, 9, 600), word(1'b0, 11, 77)};
    open_win();
    for (int i = 0; i < 32; i++) begin
      clock_bit(s[31-i]);
      if (i >= 15) chk("R9 sdo tap", int'(sdo), int'(s[31-(i-15)]));
    end
    close_win();
    exp_code[11] = 10'd77;
    check_all("R7 last 16");
  endtask

  task automatic t_gated();
    logic [15:0] w;
    logic        held;
    held = sdo;
    w = word(1'b0, 5, 777);
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(6); sck = 1'b1;
      wait_clk(6); sck = 1'b0;
      wait_clk(6);
      chk("R8 sdo held", int'(sdo), int'(held));
    end
    sel_n = 1'b0;
    wait_clk(6);
    close_win();
    check_all("R8 no write");
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) exp_code[k] = '0;
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_writes();
    t_bad_addr();
    t_ctrl();
    t_short();
    t_long_chain();
    t_gated();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule